// File: doc/BRIEF.md
# Vectored Interrupt Status Controller

This block collects interrupt requests for a small microcontroller core and presents them as one 8-bit status/control register. It has three latched request sources: an edge on an external interrupt pin, an edge on a second pin that normally clocks a timer, and an overflow pulse from a timer. A fourth request bit is derived from a group of peripheral flags, each qualified by its own peripheral enable. Every source has its own enable bit. A global-disable bit, held in the block, masks everything.

When an enabled source is pending and global disable is clear, the block raises a request to the core and shows a fixed vector address for the winning source. The core acknowledges, and the block then clears that source's flag and sets global disable, so the handler is not re-entered. Request flags latch whether or not they are enabled. If software clears an enable in the same cycle that its flag is raised, with interrupts globally enabled, the block takes a vector to address 0x00 instead.

Top module: `irq_status_ctrl`

## Requirements
- R1: During reset and after its release, the register reads 0x00, global disable reads 0 and no request is raised (peripheral inputs at 0).
- R2: Register bit layout: bit 7 peripheral summary, bit 6 clock-pin flag, bit 5 timer flag, bit 4 interrupt-pin flag, bit 3 peripheral enable, bit 2 clock-pin enable, bit 1 timer enable, bit 0 interrupt-pin enable. A write stores bits 6..0.
- R3: Bit 7 always reads the OR of (peripheral flag AND peripheral enable) over all peripherals. Writes to bit 7 have no effect.
- R4: The three latched flags are set by their event whatever the state of their enables and of global disable.
- R5: Each pin flag sets on the edge chosen by its polarity input (1 = rising, 0 = falling) of a synchronized copy of the pin. A pin change made before clock edge k is visible in the flag after edge k+2, and not after edge k+1. The other edge does not set the flag.
- R6: A timer overflow pulse sampled at a clock edge sets the timer flag at that edge.
- R7: A request is raised exactly when global disable is 0 and either some flag with its enable is set, the peripheral summary is set with peripheral enable set, or a pending address-zero event exists.
- R8: Vector addresses, in descending priority: 0x00 address-zero event, 0x08 interrupt pin, 0x10 timer, 0x18 clock pin, 0x20 peripheral group.
- R9: An acknowledge while a request is raised clears the flag of the vectored source (the peripheral summary is not cleared), clears a pending address-zero event, and sets global disable.
- R10: If a hardware set and a software write of 0 hit the same flag in one cycle, the flag ends up set.
- R11: With global disable 0, a write that clears an enable in the same cycle that the matching flag (or the peripheral summary) rises leaves a pending address-zero event, which requests vector 0x00. With global disable 1 no such event arises.
- R12: Global disable is written through its own port. An acknowledge in the same cycle takes precedence and sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_int | input | 1 | External interrupt pin, asynchronous |
| pin_ck | input | 1 | External clock pin, asynchronous |
| pol_int | input | 1 | Edge select for pin_int, 1 = rising |
| pol_ck | input | 1 | Edge select for pin_ck, 1 = rising |
| tmr_ovf | input | 1 | Timer overflow pulse |
| periph_flag | input | NUM_PERIPH | Peripheral request flags |
| periph_en | input | NUM_PERIPH | Per-peripheral enables |
| reg_we | input | 1 | Status/control register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| gdis_we | input | 1 | Global-disable write strobe |
| gdis_wdata | input | 1 | Global-disable write value |
| gdis_q | output | 1 | Current global disable |
| irq_req | output | 1 | Interrupt request to the core |
| irq_ack | input | 1 | Acknowledge from the core |
| irq_vector | output | 8 | Vector address of the current request |

## Verification
The hardest situation to reach is the address-zero event. A flag must rise in exactly the cycle in which a register write drops its enable, while global disable is clear. The pin flags arrive through a synchronizer, so the bench uses the timer pulse for this, because it sets its flag at the edge where it is sampled. The bench then drives the pulse and the enable-clearing write in one cycle, and repeats the same stimulus with global disable set as the negative case. A sweep over all sixteen combinations of pending sources checks priority and the clear on acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W      = 8;
  localparam int NUM_SRC    = 4;   // 0 int pin, 1 timer, 2 clock pin, 3 peripheral
  localparam int NUM_LATCH  = 3;   // sources with a latched flag
  localparam int VEC_W      = 8;
  localparam int VEC_STEP   = 8;
  localparam logic [VEC_W-1:0] VEC_ZERO = '0;

  localparam int BIT_PSUM   = 7;
  localparam int BIT_FLAG0  = 4;
  localparam int BIT_EN0    = 0;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic pol_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;
  logic              lvl;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign lvl    = sync_q[STAGES-1];
  assign edge_o = pol_i ? (lvl & ~prev_q) : (~lvl & prev_q);

  // a synchronized level gives at most one edge per change
  assert_edge_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o && $stable(pol_i) |=> !edge_o);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_pkg::*;
(
  input  logic                trap_i,
  input  logic [NUM_SRC-1:0]  pend_i,
  output logic                trap_sel_o,
  output logic [NUM_SRC-1:0]  grant_o,
  output logic [VEC_W-1:0]    vector_o
);
  logic found;

  always_comb begin
    grant_o    = '0;
    vector_o   = VEC_ZERO;
    trap_sel_o = trap_i;
    found      = trap_i;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!found && pend_i[i]) begin
        grant_o[i] = 1'b1;
        vector_o   = VEC_W'((i + 1) * VEC_STEP);
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    assert_one_winner_R8: assert ($onehot0({trap_sel_o, grant_o}));
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_PERIPH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pin_int,
  input  logic                  pin_ck,
  input  logic                  pol_int,
  input  logic                  pol_ck,
  input  logic                  tmr_ovf,
  input  logic [NUM_PERIPH-1:0] periph_flag,
  input  logic [NUM_PERIPH-1:0] periph_en,
  input  logic                  reg_we,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  input  logic                  gdis_we,
  input  logic                  gdis_wdata,
  output logic                  gdis_q,
  output logic                  irq_req,
  input  logic                  irq_ack,
  output logic [VEC_W-1:0]      irq_vector
);
  logic                 rst_i_n;
  logic                 edge_int, edge_ck;
  logic [NUM_LATCH-1:0] flag_q, flag_d, hw_set, hw_clr, flag_base;
  logic [NUM_SRC-1:0]   en_q, en_d, en_fall, rise_evt, pend, grant;
  logic                 trap_q, trap_d, trap_sel, new_trap;
  logic                 gdis_d;
  logic                 psum, psum_q;
  logic                 take;
  logic                 unused_wbit;

  irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  irq_edge_detect #(.STAGES(SYNC_STAGES)) u_edge_int (
    .clk(clk), .rst_n(rst_i_n), .pin_i(pin_int), .pol_i(pol_int), .edge_o(edge_int));

  irq_edge_detect #(.STAGES(SYNC_STAGES)) u_edge_ck (
    .clk(clk), .rst_n(rst_i_n), .pin_i(pin_ck), .pol_i(pol_ck), .edge_o(edge_ck));

  assign psum        = |(periph_flag & periph_en);
  assign hw_set      = {edge_ck, tmr_ovf, edge_int};
  assign pend        = {psum & en_q[NUM_SRC-1], flag_q & en_q[NUM_LATCH-1:0]};
  assign irq_req     = ~gdis_q & (trap_q | (|pend));
  assign take        = irq_ack & irq_req;
  assign unused_wbit = reg_wdata[BIT_PSUM];

  irq_prio_enc u_prio (
    .trap_i(trap_q), .pend_i(pend), .trap_sel_o(trap_sel),
    .grant_o(grant), .vector_o(irq_vector));

  // next state
  always_comb begin
    hw_clr    = {NUM_LATCH{take}} & grant[NUM_LATCH-1:0];
    flag_base = reg_we ? reg_wdata[BIT_FLAG0 +: NUM_LATCH] : flag_q;
    flag_d    = hw_set | (flag_base & ~hw_clr);
    en_d      = reg_we ? reg_wdata[BIT_EN0 +: NUM_SRC] : en_q;
    en_fall   = {NUM_SRC{reg_we}} & en_q & ~reg_wdata[BIT_EN0 +: NUM_SRC];
    rise_evt  = {psum & ~psum_q, hw_set & ~flag_q};
    new_trap  = ~gdis_q & (|(rise_evt & en_fall));
    trap_d    = (trap_q & ~(take & trap_sel)) | new_trap;
    if (take)         gdis_d = 1'b1;
    else if (gdis_we) gdis_d = gdis_wdata;
    else              gdis_d = gdis_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      flag_q <= '0;
      en_q   <= '0;
      trap_q <= 1'b0;
      gdis_q <= 1'b0;
      psum_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      psum_q <= psum;
      trap_q <= trap_d;
      if (reg_we)           en_q   <= en_d;
      if (take || gdis_we)  gdis_q <= gdis_d;
    end
  end

  assign reg_rdata = {psum, flag_q, en_q};

  assert_ack_masks_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    take |=> gdis_q && !irq_req);
  assert_ack_clears_int_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    take && irq_vector == VEC_W'(VEC_STEP) && !edge_int |=> !reg_rdata[BIT_FLAG0]);
  assert_tmr_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    tmr_ovf |=> reg_rdata[BIT_FLAG0 + 1]);
  assert_psum_gated_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(|periph_en) |-> !reg_rdata[BIT_PSUM]);
  assert_zero_vector_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    !gdis_q && !irq_ack && !gdis_we && reg_we && tmr_ovf && !reg_rdata[BIT_FLAG0 + 1]
      && reg_rdata[BIT_EN0 + 1] && !reg_wdata[BIT_EN0 + 1]
    |=> irq_req && irq_vector == VEC_ZERO);
endmodule

// File: tb/irq_status_ctrl_bench.sv
module irq_status_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pin_int = 0, pin_ck = 0, pol_int = 1, pol_ck = 1, tmr_ovf = 0;
  logic [NP-1:0] periph_flag = '0, periph_en = '0;
  logic reg_we = 0, gdis_we = 0, gdis_wdata = 0, irq_ack = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata, irq_vector;
  logic gdis_q, irq_req;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_ctrl #(.NUM_PERIPH(NP), .SYNC_STAGES(2)) u_irq_status_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_int(pin_int), .pin_ck(pin_ck),
    .pol_int(pol_int), .pol_ck(pol_ck), .tmr_ovf(tmr_ovf),
    .periph_flag(periph_flag), .periph_en(periph_en),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .gdis_we(gdis_we), .gdis_wdata(gdis_wdata), .gdis_q(gdis_q),
    .irq_req(irq_req), .irq_ack(irq_ack), .irq_vector(irq_vector));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    reg_we = 1; reg_wdata = d; tick(); reg_we = 0;
  endtask

  task automatic set_gdis(input logic v);
    gdis_we = 1; gdis_wdata = v; tick(); gdis_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 0);
    $finish;
  end

  initial begin
    repeat (3) tick();
    check("R1 reg in reset", reg_rdata, 8'h00);
    check("R1 req in reset", irq_req, 0);
    rst_n = 1;
    repeat (4) tick();
    check("R1 reg after reset", reg_rdata, 8'h00);
    check("R1 gdis after reset", gdis_q, 0);
    check("R1 req after reset", irq_req, 0);

    // R2 storage of bits 6..0, R3 bit 7 write ignored
    set_gdis(1);
    wr(8'hFF);
    check("R2 R3 write all ones", reg_rdata, 8'h7F);
    wr(8'h2A);
    check("R2 pattern", reg_rdata, 8'h2A);
    wr(8'h00);

    // R3 exhaustive peripheral summary
    for (int f = 0; f < 16; f++)
      for (int e = 0; e < 16; e++) begin
        periph_flag = 4'(f); periph_en = 4'(e); #1;
        check("R3 peripheral summary", reg_rdata[7], ((f & e) != 0));
      end
    periph_flag = 0; periph_en = 0;

    // R4 R6 timer latches while masked and globally disabled
    tmr_ovf = 1; tick(); tmr_ovf = 0;
    check("R4 R6 timer flag masked", reg_rdata, 8'h20);
    check("R4 no request when masked", irq_req, 0);
    // R10 set beats write-0
    tmr_ovf = 1; wr(8'h00); tmr_ovf = 0;
    check("R10 set wins over write 0", reg_rdata[5], 1);
    wr(8'h00);

    // R5 edge sweep: source, polarity, direction
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < 2; p++)
        for (int d = 0; d < 2; d++) begin
          if (s == 0) begin pol_int = p[0]; pin_int = ~d[0]; end
          else        begin pol_ck  = p[0]; pin_ck  = ~d[0]; end
          repeat (4) tick();
          wr(8'h00);
          if (s == 0) pin_int = d[0]; else pin_ck = d[0];
          tick(); tick();
          check("R5 flag not yet set", reg_rdata[6:4], 0);
          tick();
          check("R5 edge polarity", s == 0 ? reg_rdata[4] : reg_rdata[6], (p == d));
        end
    pin_int = 0; pin_ck = 0; repeat (4) tick(); wr(8'h00);

    // R7 R8 R9 priority sweep over all pending sets
    periph_en = 4'hF;
    for (int m = 0; m < 16; m++) begin
      logic [7:0] ev; logic [2:0] fl;
      set_gdis(0);
      periph_flag = m[3] ? 4'b0100 : 4'b0000;
      wr({1'b0, m[2], m[1], m[0], 4'hF});
      ev = m[0] ? 8'h08 : m[1] ? 8'h10 : m[2] ? 8'h18 : 8'h20;
      check("R7 request", irq_req, (m != 0));
      if (m != 0) begin
        check("R8 vector", irq_vector, ev);
        fl = m[2:0];
        if (ev == 8'h08) fl[0] = 0; else if (ev == 8'h10) fl[1] = 0;
        else if (ev == 8'h18) fl[2] = 0;
        irq_ack = 1; tick(); irq_ack = 0;
        check("R9 flag cleared", reg_rdata[6:4], fl);
        check("R9 summary kept", reg_rdata[7], m[3]);
        check("R9 gdis set", gdis_q, 1);
        check("R7 masked after ack", irq_req, 0);
      end
      set_gdis(1);
      periph_flag = 0; wr(8'h00);
    end
    periph_en = 0;

    // R12 ack wins over gdis write of 0
    set_gdis(0);
    wr(8'h11);
    check("R7 int request", irq_req, 1);
    gdis_we = 1; gdis_wdata = 0; irq_ack = 1; tick(); gdis_we = 0; irq_ack = 0;
    check("R12 ack beats gdis write", gdis_q, 1);
    set_gdis(0);
    check("R12 gdis written 0", gdis_q, 0);
    wr(8'h00);

    // R11 address-zero event
    wr(8'h02);
    check("R11 no request before", irq_req, 0);
    tmr_ovf = 1; wr(8'h00); tmr_ovf = 0;
    check("R11 request", irq_req, 1);
    check("R11 vector zero", irq_vector, 8'h00);
    check("R11 flag latched", reg_rdata, 8'h20);
    irq_ack = 1; tick(); irq_ack = 0;
    check("R9 gdis after zero vector", gdis_q, 1);
    set_gdis(0);
    check("R9 zero event cleared", irq_req, 0);
    // negative case with global disable set
    wr(8'h02); set_gdis(1);
    tmr_ovf = 1; wr(8'h00); tmr_ovf = 0;
    set_gdis(0);
    check("R11 no event when disabled", irq_req, 0);
    // peripheral summary rise with enable drop
    wr(8'h08); periph_en = 4'h1;
    periph_flag = 4'h1; wr(8'h00);
    check("R11 peripheral zero vector", {irq_req, irq_vector}, 9'h100);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule